// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Voting

This block owns the mode register of an analog PLL and drives its three control pins: leave-bypass, active-low reset and output enable. The PLL has to come up in a strict order. First it leaves bypass. After a settling gap its reset is released. Once it has had time to lock, the output is switched on. Shutdown clears all three pins in one step.

Software can drive the pins directly by writing the register, or start the timed bring-up with a one-cycle enable pulse. In vote mode, a hardware state machine raises the PLL whenever any bit of a voter vector is high and powers it down when none is. That machine takes its two wait lengths from the register and also waits for the lock input. Waits are counted in pulses of a microsecond tick input. A timeout flag tells voters that the PLL did not become ready in time.

Top module: `pllseq_top`

## Requirements
- R1: After reset all three PLL pins, `pll_ready` and `vote_late` are low. The register reads 0x204800: lock wait 8, bias wait 1, vote machine held, vote mode off.
- R2: Register layout: bit 0 output enable, bit 1 leave-bypass, bit 2 reset release, bits 13:8 lock wait, bits 19:14 bias wait, bit 20 vote mode, bit 21 vote machine hold. Bits 7:3 read zero. `reg_rdata` reflects a write two clock edges after the write edge.
- R3: A write with bit 20 clear loads bits 2:0 onto the pins at the write edge. `pll_ready` is high exactly when all three pins are high.
- R4: In manual mode, a `man_enable` pulse raises leave-bypass at that edge. Reset is released MAN_GAP_US+1 counted ticks later, and the output is enabled MAN_LOCK_US+1 ticks after that, whatever the lock input does. A pulse while all three pins are already high changes nothing.
- R5: Shutdown, whether from `man_disable` or from all votes dropping, clears all three pins at the same edge, even in the middle of the sequence.
- R6: While vote mode is on, `man_enable` and `man_disable` are ignored. A write with bit 20 set leaves the pins unchanged.
- R7: With both bit 20 and bit 21 set, the pins are held low whatever the votes.
- R8: In vote mode, with the tick high every cycle, the first vote raises leave-bypass at that edge. Reset is released after bias-wait+1 further edges. The output rises after lock-wait+1 more edges, and only once `pll_lock` is high.
- R9: Votes that change without all of them dropping neither disturb the sequence timing nor glitch the output enable.
- R10: `vote_late` rises TIMEOUT_US ticks after a vote starts waiting without the PLL becoming ready. It clears at the edge after all votes drop.
- R11: Wait counters advance only on edges where `us_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 22 | Mode register write data |
| reg_rdata | output | 22 | Registered mode register view |
| man_enable | input | 1 | Manual bring-up request pulse |
| man_disable | input | 1 | Manual shutdown request pulse |
| vote_req | input | NUM_VOTERS | Vote request vector |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_bypass_off | output | 1 | High takes the PLL out of bypass |
| pll_reset_n | output | 1 | Active-low PLL reset |
| pll_out_en | output | 1 | PLL output enable |
| pll_ready | output | 1 | All three control pins are high |
| vote_late | output | 1 | A vote has waited past the timeout |

## Verification
Every pin change is due at the clock edge that samples its cause. So the bench drives at the falling edge and counts rising edges until each pin flips. For the vote and manual sequences, the expected counts are 1 for leave-bypass, wait+2 for reset release and both waits+3 for the output, with the tick held high. The register view lags one more edge, so it is read two edges after a write. The timeout flag is expected exactly TIMEOUT_US edges after the vote, and its clearing one edge after the votes drop.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int REG_W    = 22;
  localparam int FLD_W    = 6;
  localparam int B_OUT    = 0;
  localparam int B_BYP    = 1;
  localparam int B_RSTN   = 2;
  localparam int LOCK_LSB = 8;
  localparam int BIAS_LSB = 14;
  localparam int B_VEN    = 20;
  localparam int B_VRST   = 21;
  localparam int LOCK_RST = 8;
  localparam int BIAS_RST = 1;

  typedef enum logic [1:0] {ST_OFF, ST_BIAS, ST_LOCK, ST_ON} seq_st_e;

  function automatic logic [REG_W-1:0] view(input logic vrst, input logic ven,
                                            input logic [FLD_W-1:0] bias,
                                            input logic [FLD_W-1:0] lock,
                                            input logic [2:0] ctrl);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_VRST] = vrst;
    v[B_VEN] = ven;
    v[BIAS_LSB +: FLD_W] = bias;
    v[LOCK_LSB +: FLD_W] = lock;
    v[2:0] = ctrl;
    return v;
  endfunction
endpackage

// File: rtl/pllseq_regs.sv
module pllseq_regs
  import pllseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [2:0]       ctrl_cur,
  output logic [FLD_W-1:0] lock_lim,
  output logic [FLD_W-1:0] bias_lim,
  output logic             vote_en,
  output logic             vote_rst,
  output logic [REG_W-1:0] rdata,
  output logic             ld,
  output logic [2:0]       ld_ctrl
);
  logic unused_bits;
  assign unused_bits = ^wdata[7:3];

  assign ld      = we && !wdata[B_VEN];
  assign ld_ctrl = wdata[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_lim <= FLD_W'(LOCK_RST);
      bias_lim <= FLD_W'(BIAS_RST);
      vote_en  <= 1'b0;
      vote_rst <= 1'b1;
      rdata    <= view(1'b1, 1'b0, FLD_W'(BIAS_RST), FLD_W'(LOCK_RST), 3'b000);
    end else begin
      if (we) begin
        lock_lim <= wdata[LOCK_LSB +: FLD_W];
        bias_lim <= wdata[BIAS_LSB +: FLD_W];
        vote_en  <= wdata[B_VEN];
        vote_rst <= wdata[B_VRST];
      end
      rdata <= view(vote_rst, vote_en, bias_lim, lock_lim, ctrl_cur);
    end
  end
endmodule

// File: rtl/pllseq_seq.sv
module pllseq_seq
  import pllseq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MAN_GAP  = 10,
  parameter int MAN_LOCK = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vote_en,
  input  logic             vote_rst,
  input  logic             vote_any,
  input  logic             man_en,
  input  logic             man_dis,
  input  logic             ld,
  input  logic [2:0]       ld_ctrl,
  input  logic [FLD_W-1:0] bias_lim,
  input  logic [FLD_W-1:0] lock_lim,
  input  logic             tick,
  input  logic             lock_in,
  output logic [2:0]       ctrl_o,
  output logic             ready_o
);
  localparam logic [2:0] C_OFF  = 3'b000;
  localparam logic [2:0] C_BYP  = 3'b010;
  localparam logic [2:0] C_RLS  = 3'b110;
  localparam logic [2:0] C_FULL = 3'b111;

  seq_st_e          st_q, st_d;
  logic [2:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mgo_q, mgo_d;
  logic             go;
  logic [CNT_W-1:0] gap_w, lock_w;
  logic             need_lock;

  always_comb begin
    gap_w     = vote_en ? CNT_W'(bias_lim) : CNT_W'(MAN_GAP);
    lock_w    = vote_en ? CNT_W'(lock_lim) : CNT_W'(MAN_LOCK);
    need_lock = vote_en;
    mgo_d     = vote_en ? 1'b0 : ((mgo_q || man_en) && !man_dis);
    go        = vote_en ? (vote_any && !vote_rst) : mgo_d;
    st_d      = st_q;
    ctrl_d    = ctrl_q;
    cnt_d     = cnt_q;
    if (ld) begin
      ctrl_d = ld_ctrl;
      st_d   = (ld_ctrl == C_FULL) ? ST_ON : ST_OFF;
      mgo_d  = (ld_ctrl == C_FULL);
      cnt_d  = '0;
    end else if (vote_en && vote_rst) begin
      st_d   = ST_OFF;
      ctrl_d = C_OFF;
      cnt_d  = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (go) begin
            cnt_d = '0;
            if (ctrl_q == C_FULL) begin
              st_d = ST_ON;
            end else begin
              st_d   = ST_BIAS;
              ctrl_d = C_BYP;
            end
          end else if (vote_en || man_dis) begin
            ctrl_d = C_OFF;
          end
        end
        ST_BIAS: begin
          if (!go) begin
            st_d   = ST_OFF;
            ctrl_d = C_OFF;
          end else if (cnt_q >= gap_w) begin
            st_d   = ST_LOCK;
            ctrl_d = C_RLS;
            cnt_d  = '0;
          end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (!go) begin
            st_d   = ST_OFF;
            ctrl_d = C_OFF;
          end else if (cnt_q >= lock_w && (lock_in || !need_lock)) begin
            st_d   = ST_ON;
            ctrl_d = C_FULL;
          end else if (tick && cnt_q != '1) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (!go) begin
            st_d   = ST_OFF;
            ctrl_d = C_OFF;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OFF;
      ctrl_q  <= C_OFF;
      cnt_q   <= '0;
      mgo_q   <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      mgo_q   <= mgo_d;
      ready_o <= (ctrl_d == C_FULL);
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pllseq_watch.sv
module pllseq_watch #(
  parameter int TIMEOUT_US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic vote_en,
  input  logic vote_rst,
  input  logic vote_any,
  input  logic ready,
  input  logic tick,
  output logic late
);
  localparam int TW = $clog2(TIMEOUT_US + 1);
  logic [TW-1:0] cnt_q;
  logic          waiting;

  assign waiting = vote_en && !vote_rst && vote_any;

  always_ff @(posedge clk) begin
    if (rst || !waiting) begin
      cnt_q <= '0;
      late  <= 1'b0;
    end else if (ready) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == TW'(TIMEOUT_US - 1)) late <= 1'b1;
      if (cnt_q < TW'(TIMEOUT_US)) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int NUM_VOTERS  = 4,
  parameter int MAN_GAP_US  = 10,
  parameter int MAN_LOCK_US = 50,
  parameter int TIMEOUT_US  = 200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  man_enable,
  input  logic                  man_disable,
  input  logic [NUM_VOTERS-1:0] vote_req,
  input  logic                  us_tick,
  input  logic                  pll_lock,
  output logic                  pll_bypass_off,
  output logic                  pll_reset_n,
  output logic                  pll_out_en,
  output logic                  pll_ready,
  output logic                  vote_late
);
  localparam int MAN_MAX = (MAN_GAP_US > MAN_LOCK_US) ? MAN_GAP_US : MAN_LOCK_US;
  localparam int MAN_W   = $clog2(MAN_MAX + 1);
  localparam int CNT_W   = (MAN_W > FLD_W) ? MAN_W : FLD_W;

  logic [FLD_W-1:0] lock_lim_w, bias_lim_w;
  logic             vote_en_w, vote_rst_w, vote_any_w, ld_w;
  logic [2:0]       ld_ctrl_w, ctrl_w;

  assign vote_any_w = |vote_req;

  pllseq_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .ctrl_cur(ctrl_w),
    .lock_lim(lock_lim_w), .bias_lim(bias_lim_w), .vote_en(vote_en_w),
    .vote_rst(vote_rst_w), .rdata(reg_rdata), .ld(ld_w), .ld_ctrl(ld_ctrl_w)
  );

  pllseq_seq #(.CNT_W(CNT_W), .MAN_GAP(MAN_GAP_US), .MAN_LOCK(MAN_LOCK_US)) u_seq (
    .clk(clk), .rst(rst), .vote_en(vote_en_w), .vote_rst(vote_rst_w),
    .vote_any(vote_any_w), .man_en(man_enable), .man_dis(man_disable),
    .ld(ld_w), .ld_ctrl(ld_ctrl_w), .bias_lim(bias_lim_w), .lock_lim(lock_lim_w),
    .tick(us_tick), .lock_in(pll_lock), .ctrl_o(ctrl_w), .ready_o(pll_ready)
  );

  pllseq_watch #(.TIMEOUT_US(TIMEOUT_US)) u_watch (
    .clk(clk), .rst(rst), .vote_en(vote_en_w), .vote_rst(vote_rst_w),
    .vote_any(vote_any_w), .ready(pll_ready), .tick(us_tick), .late(vote_late)
  );

  assign pll_out_en     = ctrl_w[B_OUT];
  assign pll_bypass_off = ctrl_w[B_BYP];
  assign pll_reset_n    = ctrl_w[B_RSTN];
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk (
  input logic clk,
  input logic rst,
  input logic reg_we,
  input logic vote_en,
  input logic vote_rst,
  input logic vote_any,
  input logic pll_lock,
  input logic pll_out_en,
  input logic pll_reset_n,
  input logic pll_bypass_off,
  input logic pll_ready,
  input logic vote_late
);
  assert_single_step_off_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(pll_out_en) && !$past(reg_we)) |-> (!pll_reset_n && !pll_bypass_off));

  assert_reset_after_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(pll_reset_n) && !$past(reg_we)) |-> $past(pll_bypass_off));

  assert_output_after_reset_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(pll_out_en) && !$past(reg_we)) |-> $past(pll_reset_n));

  assert_vote_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(pll_out_en) && !$past(reg_we) && $past(vote_en)) |-> $past(pll_lock));

  assert_hold_pins_low_R7: assert property (@(posedge clk) disable iff (rst)
    (vote_en && vote_rst && !reg_we) |=> (!pll_out_en && !pll_reset_n && !pll_bypass_off));

  assert_ready_full_R3: assert property (@(posedge clk) disable iff (rst)
    pll_ready |-> (pll_out_en && pll_reset_n && pll_bypass_off));

  assert_late_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !vote_any |=> !vote_late);
endmodule

bind pllseq_top pllseq_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .vote_en(vote_en_w), .vote_rst(vote_rst_w),
  .vote_any(vote_any_w), .pll_lock(pll_lock), .pll_out_en(pll_out_en),
  .pll_reset_n(pll_reset_n), .pll_bypass_off(pll_bypass_off),
  .pll_ready(pll_ready), .vote_late(vote_late)
);

// File: tb/pllseq_top_tb.sv
module pllseq_top_tb;
  localparam int NV = 2;
  localparam int GAP = 3;
  localparam int LCK = 5;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [21:0] reg_wdata = '0;
  logic [21:0] reg_rdata;
  logic man_enable = 1'b0, man_disable = 1'b0;
  logic [NV-1:0] vote_req = '0;
  logic us_tick = 1'b1, pll_lock = 1'b0;
  logic pll_bypass_off, pll_reset_n, pll_out_en, pll_ready, vote_late;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pllseq_top #(.NUM_VOTERS(NV), .MAN_GAP_US(GAP), .MAN_LOCK_US(LCK), .TIMEOUT_US(TMO)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .man_enable(man_enable), .man_disable(man_disable), .vote_req(vote_req),
    .us_tick(us_tick), .pll_lock(pll_lock), .pll_bypass_off(pll_bypass_off),
    .pll_reset_n(pll_reset_n), .pll_out_en(pll_out_en), .pll_ready(pll_ready),
    .vote_late(vote_late)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int pins();
    return {29'd0, pll_reset_n, pll_bypass_off, pll_out_en};
  endfunction

  function automatic logic [21:0] modew(input bit ven, input bit vrst,
                                        input int bias, input int lck, input int c);
    return {vrst, ven, 6'(bias), 6'(lck), 5'd0, 3'(c)};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      man_enable = 1'b0;
      man_disable = 1'b0;
    end
  endtask

  task automatic wr(input logic [21:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_seq(input int swap_at, output int t_byp, output int t_rst, output int t_out);
    t_byp = 0; t_rst = 0; t_out = 0;
    for (int k = 1; k <= 300; k++) begin
      step(1);
      if (k == swap_at) vote_req = 2'b10;
      if (pll_bypass_off && t_byp == 0) t_byp = k;
      if (pll_reset_n && t_rst == 0) t_rst = k;
      if (pll_out_en) begin
        t_out = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int tb, tr, to;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pins", pins(), 0);
    chk("R1 ready", int'(pll_ready), 0);
    chk("R1 late", int'(vote_late), 0);
    chk("R1 reg", int'(reg_rdata), 'h204800);

    // R3 direct writes in manual mode
    wr(modew(0, 0, 0, 0, 2));
    chk("R3 bypass-only pins", pins(), 2);
    chk("R3 ready low", int'(pll_ready), 0);
    step(1);
    chk("R2 readback ctrl", int'(reg_rdata), 2);
    wr(modew(0, 0, 0, 0, 7));
    chk("R3 full pins", pins(), 7);
    chk("R3 ready high", int'(pll_ready), 1);
    wr(modew(0, 0, 0, 0, 0));
    chk("R3 cleared", pins(), 0);

    // R4 manual bring-up, lock input held low
    pll_lock = 1'b0;
    man_enable = 1'b1;
    run_seq(0, tb, tr, to);
    chk("R4 bypass edge", tb, 1);
    chk("R4 reset edge", tr, GAP + 2);
    chk("R4 output edge", to, GAP + LCK + 3);
    chk("R4 ready", int'(pll_ready), 1);
    man_enable = 1'b1;
    step(3);
    chk("R4 enable when on", pins(), 7);

    // R5 manual shutdown, when on and mid-sequence
    man_disable = 1'b1;
    step(1);
    chk("R5 manual off", pins(), 0);
    chk("R5 ready off", int'(pll_ready), 0);
    man_enable = 1'b1;
    step(GAP + 3);
    chk("R4 mid sequence", pins(), 6);
    man_disable = 1'b1;
    step(1);
    chk("R5 mid-sequence off", pins(), 0);

    // R7 vote machine held
    wr(modew(1, 1, 1, 1, 0));
    vote_req = 2'b01;
    step(6);
    chk("R7 held pins", pins(), 0);
    vote_req = '0;

    // R6 vote mode ignores manual requests and ctrl bits
    wr(modew(1, 0, 2, 3, 0));
    step(1);
    chk("R2 readback fields", int'(reg_rdata), int'(modew(1, 0, 2, 3, 0)));
    man_enable = 1'b1;
    step(4);
    chk("R6 man enable ignored", pins(), 0);
    wr(modew(1, 0, 2, 3, 7));
    chk("R6 write ctrl ignored", pins(), 0);
    step(1);
    chk("R6 readback ctrl", int'(reg_rdata[2:0]), 0);

    // R8 sweep of bias and lock waits
    pll_lock = 1'b1;
    for (int b = 0; b < 5; b++) begin
      for (int l = 0; l < 5; l++) begin
        wr(modew(1, 0, b, l, 0));
        vote_req = 2'b01;
        run_seq(0, tb, tr, to);
        chk($sformatf("R8 b%0d l%0d bypass", b, l), tb, 1);
        chk($sformatf("R8 b%0d l%0d reset", b, l), tr, b + 2);
        chk($sformatf("R8 b%0d l%0d output", b, l), to, b + l + 3);
        chk("R8 ready", int'(pll_ready), 1);
        vote_req = '0;
        step(1);
        chk("R5 vote drop off", pins(), 0);
      end
    end

    // R8 lock input gating
    pll_lock = 1'b0;
    wr(modew(1, 0, 1, 1, 0));
    vote_req = 2'b01;
    step(10);
    chk("R8 waits for lock", pins(), 6);
    pll_lock = 1'b1;
    step(1);
    chk("R8 lock then on", pins(), 7);
    vote_req = '0;
    step(1);

    // R9 voter changes
    wr(modew(1, 0, 3, 3, 0));
    vote_req = 2'b01;
    run_seq(2, tb, tr, to);
    chk("R9 reset timing kept", tr, 5);
    chk("R9 output timing kept", to, 9);
    vote_req = 2'b11;
    step(1);
    chk("R9 on with 11", pins(), 7);
    vote_req = 2'b01;
    step(1);
    chk("R9 on with 01", pins(), 7);
    vote_req = '0;
    step(1);

    // R10 timeout flag
    pll_lock = 1'b0;
    wr(modew(1, 0, 0, 0, 0));
    vote_req = 2'b01;
    step(TMO - 1);
    chk("R10 not yet late", int'(vote_late), 0);
    step(1);
    chk("R10 late", int'(vote_late), 1);
    vote_req = '0;
    step(1);
    chk("R10 late clears", int'(vote_late), 0);

    // R11 tick gating
    pll_lock = 1'b1;
    us_tick = 1'b0;
    wr(modew(1, 0, 2, 0, 0));
    vote_req = 2'b01;
    step(10);
    chk("R11 no ticks holds", pins(), 2);
    us_tick = 1'b1;
    step(3);
    chk("R11 ticks release", pins(), 6);
    vote_req = '0;
    step(1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule